// File: doc/BRIEF.md
# Receive Character Queue with Error Flags and Flow Control

This block is the holding stage between a serial receiver's shift register and the host that reads received characters. It stores up to three characters. Each one keeps its own parity-error, framing-error and line-break flags. With the shift register in front, the receive path can therefore buffer four characters. The host sees a ready flag, a full flag, the character at the head of the queue and a three-flag status. The status either follows the head character alone or collects the flags of every character that has reached the head since the host last cleared errors.

A fill-level state machine tracks occupancy in four states: Q_EMPTY, Q_ONE, Q_TWO and Q_FULL. An accepted push with no effective pop moves one state up, through the transitions EMPTY to ONE, ONE to TWO and TWO to FULL. An effective pop with no accepted push moves one state down, through FULL to TWO, TWO to ONE and ONE to EMPTY. A push and a pop in the same cycle leave the level unchanged. A receiver reset moves every state to Q_EMPTY.

A second state machine drives the request-to-send output. It has two states, RTS_LIVE (output low, asserted) and RTS_HOLD (output high, negated). The transition LIVE to HOLD is taken when a start bit is detected while the queue is full and automatic flow control is enabled. The transition HOLD to LIVE is taken once the queue is no longer full or flow control is switched off.

A receiver reset makes the queue look empty without erasing what it stores. A pop issued while the queue is empty still moves the read pointer, so the read and write pointers stay out of step until the next receiver reset.

Top module: `rxq_top`

## Requirements
- R1: After reset, ready, full, overrun and all three status outputs are 0, rts_n is 0, and rd_data is 0.
- R2: ready is 1 while one to three characters are stored and full is 1 exactly when three are stored. Characters leave in the order they arrived, and rd_data shows the head character. A pop takes effect at the clock edge where it is sampled.
- R3: With acc_mode at 0, stat_pe, stat_fe and stat_brk equal the flags stored with the entry the read pointer selects.
- R4: With acc_mode at 1, the status is the OR of two things: the flags of every character that was at the head in any cycle since the last err_clr, and the flags of the current head when ready is 1. A pulse on err_clr clears the collected part at the next edge.
- R5: Only a pop changes the head. Pushes while characters are present, start_det and err_clr leave rd_data unchanged.
- R6: A push while full with no pop in the same cycle discards the new character and sets overrun. Overrun stays at 1 through pops and pushes and clears only on err_clr.
- R7: With flow_en at 1, start_det while full drives rts_n to 1 at the next edge. rts_n returns to 0 one edge after full has dropped.
- R8: start_det has no effect on rts_n while the queue is not full or while flow_en is 0.
- R9: rx_reset empties the queue (ready 0, full 0), points both pointers at entry 0 and clears entry 0's flags. It leaves the stored data bytes in place, so rd_data still shows entry 0's old byte. A push in the same cycle as rx_reset is dropped.
- R10: A pop while the queue is empty leaves the queue empty but advances the read pointer (order 0,1,2,0). A following push is stored at the write pointer while the head shows the stale entry.
- R11: A push and a pop in the same cycle while full are both accepted: the queue stays full, the head advances and the new character is queued last.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push | input | 1 | Receiver has completed a character |
| push_data | input | 8 | Completed character |
| push_pe | input | 1 | Parity error for the completed character |
| push_fe | input | 1 | Framing error for the completed character |
| push_brk | input | 1 | Line break for the completed character |
| start_det | input | 1 | Valid start bit detected (one-cycle pulse) |
| pop | input | 1 | Host data read has completed |
| err_clr | input | 1 | Reset-error command |
| rx_reset | input | 1 | Receiver-reset command |
| acc_mode | input | 1 | 0 = status of the head character, 1 = accumulated status |
| flow_en | input | 1 | Enables automatic request-to-send control |
| rd_data | output | 8 | Character at the read pointer |
| ready | output | 1 | At least one character stored |
| full | output | 1 | All three entries stored |
| stat_pe | output | 1 | Reported parity error |
| stat_fe | output | 1 | Reported framing error |
| stat_brk | output | 1 | Reported line break |
| overrun | output | 1 | Sticky overrun flag |
| rts_n | output | 1 | Request to send, active low |

## Verification
A wrong fill state shows up in ready or full at the edge after the push or pop that caused it, and rd_data goes wrong on the next pop. A skewed read or write pointer gives a wrong rd_data, or wrong per-character flags, at the first pop where the order matters. A fault in the accumulated status or the overrun flag lasts until the next err_clr and is visible the cycle after the triggering event. A fault in the request-to-send state machine shows on rts_n one edge after a start_det while full, or one edge after full drops.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int QDEPTH = 3;
    localparam int PTR_W  = $clog2(QDEPTH);
    localparam int FLAG_W = 3;
    localparam int FLG_PE  = 0;
    localparam int FLG_FE  = 1;
    localparam int FLG_BRK = 2;

    typedef enum logic [1:0] {Q_EMPTY, Q_ONE, Q_TWO, Q_FULL} fill_e;
    typedef enum logic {RTS_LIVE, RTS_HOLD} rts_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [W-1:0]      push_data,
    input  logic [FLAG_W-1:0] push_flags,
    input  logic              pop,
    input  logic              rx_reset,
    output logic [W-1:0]      head_data,
    output logic [FLAG_W-1:0] head_flags,
    output logic              ready,
    output logic              full,
    output logic              ovr_evt
);
    fill_e fill_q, fill_d;
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic [W-1:0]      data_mem [QDEPTH];
    logic [FLAG_W-1:0] flag_mem [QDEPTH];
    logic push_ok, pop_real;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(QDEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_ok  = push && !rx_reset && (fill_q != Q_FULL || pop);
    assign pop_real = pop && (fill_q != Q_EMPTY);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fill_q <= Q_EMPTY;
        else        fill_q <= fill_d;
    end

    // next state
    always_comb begin
        fill_d = fill_q;
        if (rx_reset) begin
            fill_d = Q_EMPTY;
        end else begin
            unique case (fill_q)
                Q_EMPTY: if (push_ok) fill_d = Q_ONE;
                Q_ONE: begin
                    if (push_ok && !pop_real)      fill_d = Q_TWO;
                    else if (pop_real && !push_ok) fill_d = Q_EMPTY;
                end
                Q_TWO: begin
                    if (push_ok && !pop_real)      fill_d = Q_FULL;
                    else if (pop_real && !push_ok) fill_d = Q_ONE;
                end
                Q_FULL: if (pop_real && !push_ok) fill_d = Q_TWO;
            endcase
        end
    end

    // outputs
    always_comb begin
        ready      = (fill_q != Q_EMPTY);
        full       = (fill_q == Q_FULL);
        ovr_evt    = push && !rx_reset && !pop && (fill_q == Q_FULL);
        head_data  = data_mem[rd_ptr];
        head_flags = flag_mem[rd_ptr];
    end

    // pointers and storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            for (int i = 0; i < QDEPTH; i++) begin
                data_mem[i] <= '0;
                flag_mem[i] <= '0;
            end
        end else if (rx_reset) begin
            rd_ptr      <= '0;
            wr_ptr      <= '0;
            flag_mem[0] <= '0;
        end else begin
            if (push_ok) begin
                data_mem[wr_ptr] <= push_data;
                flag_mem[wr_ptr] <= push_flags;
                wr_ptr           <= ptr_inc(wr_ptr);
            end
            if (pop) rd_ptr <= ptr_inc(rd_ptr);
        end
    end

    AST_RESET_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        rx_reset |=> (fill_q == Q_EMPTY) && (rd_ptr == '0) && (wr_ptr == '0)); // R9
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q == Q_FULL) && push && !rx_reset |=> fill_q == Q_FULL); // R6
    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q == Q_TWO) && pop && !push && !rx_reset |=> fill_q == Q_ONE); // R2
    AST_EMPTY_POP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_q == Q_EMPTY) && pop && !push && !rx_reset
        |=> (fill_q == Q_EMPTY) && (rd_ptr != $past(rd_ptr))); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> wr_ptr == $past(wr_ptr)); // R6
endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] head_flags,
    input  logic              ready,
    input  logic              acc_mode,
    input  logic              err_clr,
    input  logic              ovr_evt,
    output logic [FLAG_W-1:0] stat,
    output logic              overrun
);
    logic [FLAG_W-1:0] acc_q, head_seen;

    assign head_seen = ready ? head_flags : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            overrun <= 1'b0;
        end else begin
            acc_q   <= err_clr ? '0 : (acc_q | head_seen);
            overrun <= err_clr ? 1'b0 : (overrun | ovr_evt);
        end
    end

    always_comb begin
        stat = acc_mode ? (acc_q | head_seen) : head_flags;
    end

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !err_clr |=> overrun); // R6
    AST_ACC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        !err_clr |=> (acc_q & $past(acc_q)) == $past(acc_q)); // R4
endmodule

// File: rtl/rxq_flow.sv
module rxq_flow
    import rxq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic full,
    input  logic start_det,
    input  logic flow_en,
    output logic rts_n
);
    rts_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RTS_LIVE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RTS_LIVE: if (start_det && full && flow_en) st_d = RTS_HOLD;
            RTS_HOLD: if (!full || !flow_en)            st_d = RTS_LIVE;
        endcase
    end

    always_comb begin
        rts_n = (st_q == RTS_HOLD);
    end

    AST_RTS_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        rts_n |-> $past(full)); // R8
    AST_RTS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !rts_n && start_det && full && flow_en |=> rts_n); // R7
    AST_RTS_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        rts_n && !full |=> !rts_n); // R7
endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         push_pe,
    input  logic         push_fe,
    input  logic         push_brk,
    input  logic         start_det,
    input  logic         pop,
    input  logic         err_clr,
    input  logic         rx_reset,
    input  logic         acc_mode,
    input  logic         flow_en,
    output logic [W-1:0] rd_data,
    output logic         ready,
    output logic         full,
    output logic         stat_pe,
    output logic         stat_fe,
    output logic         stat_brk,
    output logic         overrun,
    output logic         rts_n
);
    logic [FLAG_W-1:0] in_flags, head_flags, stat;
    logic ovr_evt;

    always_comb begin
        in_flags          = '0;
        in_flags[FLG_PE]  = push_pe;
        in_flags[FLG_FE]  = push_fe;
        in_flags[FLG_BRK] = push_brk;
    end

    rxq_store #(.W(W)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .push_flags(in_flags), .pop(pop), .rx_reset(rx_reset),
        .head_data(rd_data), .head_flags(head_flags), .ready(ready),
        .full(full), .ovr_evt(ovr_evt)
    );

    rxq_status u_status (
        .clk(clk), .rst_n(rst_n), .head_flags(head_flags), .ready(ready),
        .acc_mode(acc_mode), .err_clr(err_clr), .ovr_evt(ovr_evt),
        .stat(stat), .overrun(overrun)
    );

    rxq_flow u_flow (
        .clk(clk), .rst_n(rst_n), .full(full), .start_det(start_det),
        .flow_en(flow_en), .rts_n(rts_n)
    );

    assign stat_pe  = stat[FLG_PE];
    assign stat_fe  = stat[FLG_FE];
    assign stat_brk = stat[FLG_BRK];
endmodule

// File: tb/sim_rxq_top.sv
module sim_rxq_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 0, rst_n = 0;
    logic push = 0, start_det = 0, pop = 0, err_clr = 0, rx_reset = 0;
    logic acc_mode = 0, flow_en = 0;
    logic push_pe = 0, push_fe = 0, push_brk = 0;
    logic [7:0] push_data = 0;
    logic [7:0] rd_data;
    logic ready, full, stat_pe, stat_fe, stat_brk, overrun, rts_n;

    int checks = 0, errors = 0;
    bit done = 0;

    // bench model (flags packed {brk,fe,pe})
    logic [7:0] m_data [3];
    logic [2:0] m_flag [3];
    int m_rd = 0, m_wr = 0, m_cnt = 0;
    logic [2:0] m_acc = 0;
    logic m_ovr = 0, m_rtsn = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxq_top u0 (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .push_pe(push_pe), .push_fe(push_fe), .push_brk(push_brk),
        .start_det(start_det), .pop(pop), .err_clr(err_clr), .rx_reset(rx_reset),
        .acc_mode(acc_mode), .flow_en(flow_en), .rd_data(rd_data), .ready(ready),
        .full(full), .stat_pe(stat_pe), .stat_fe(stat_fe), .stat_brk(stat_brk),
        .overrun(overrun), .rts_n(rts_n)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic [2:0] hd, exp_stat;
        hd = m_flag[m_rd];
        exp_stat = acc_mode ? (m_acc | ((m_cnt > 0) ? hd : 3'b000)) : hd;
        chk(ready == (m_cnt > 0), tag, "ready", int'(ready), int'(m_cnt > 0));
        chk(full == (m_cnt == 3), tag, "full", int'(full), int'(m_cnt == 3));
        chk(rd_data == m_data[m_rd], tag, "rd_data", int'(rd_data), int'(m_data[m_rd]));
        chk({stat_brk, stat_fe, stat_pe} == exp_stat, tag, "status",
            int'({stat_brk, stat_fe, stat_pe}), int'(exp_stat));
        chk(overrun == m_ovr, tag, "overrun", int'(overrun), int'(m_ovr));
        chk(rts_n == m_rtsn, tag, "rts_n", int'(rts_n), int'(m_rtsn));
    endtask

    // one clock step: inputs held for one edge; model advanced from pre-edge state
    task automatic step(input logic p, input logic [7:0] d, input logic [2:0] f,
                        input logic po, input logic ec, input logic rr, input logic sd);
        bit was_full, push_ok, pop_real, evt;
        logic [2:0] head_seen;
        push = p; push_data = d; {push_brk, push_fe, push_pe} = f;
        pop = po; err_clr = ec; rx_reset = rr; start_det = sd;
        was_full  = (m_cnt == 3);
        head_seen = (m_cnt > 0) ? m_flag[m_rd] : 3'b000;
        evt = p && !rr && !po && was_full;
        m_acc = ec ? 3'b000 : (m_acc | head_seen);
        if (ec) m_ovr = 0; else if (evt) m_ovr = 1;
        if (!m_rtsn) begin
            if (sd && was_full && flow_en) m_rtsn = 1;
        end else if (!was_full || !flow_en) m_rtsn = 0;
        if (rr) begin
            m_rd = 0; m_wr = 0; m_cnt = 0; m_flag[0] = 3'b000;
        end else begin
            push_ok  = p && (!was_full || po);
            pop_real = po && (m_cnt > 0);
            if (push_ok) begin
                m_data[m_wr] = d; m_flag[m_wr] = f; m_wr = (m_wr + 1) % 3;
            end
            if (po) m_rd = (m_rd + 1) % 3;
            m_cnt = m_cnt + int'(push_ok) - int'(pop_real);
        end
        @(negedge clk);
        push = 0; pop = 0; err_clr = 0; rx_reset = 0; start_det = 0;
    endtask

    task automatic idle();
        step(0, 8'h00, 3'b000, 0, 0, 0, 0);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin m_data[i] = 0; m_flag[i] = 0; end
        repeat (2) @(negedge clk);
        chk(rts_n == 0 && ready == 0, "R1", "in reset", int'({rts_n, ready}), 0);
        rst_n = 1;
        @(negedge clk);
        check_all("R1");

        // R2 R3 R4: sweep all flag combinations in both status modes
        for (int mode = 0; mode < 2; mode++) begin
            acc_mode = mode[0];
            for (int f = 0; f < 8; f++) begin
                step(1, 8'(f * 17 + mode), 3'(f), 0, 0, 0, 0);
                check_all("R2");
                step(1, 8'(f * 29 + 3), 3'(f + 3), 0, 0, 0, 0);
                check_all(mode == 0 ? "R3" : "R4");
                step(1, 8'(f * 7 + 100), 3'(f + 6), 0, 0, 0, 0);
                check_all("R2");
                for (int k = 0; k < 3; k++) begin
                    step(0, 8'h00, 3'b000, 1, 0, 0, 0);
                    check_all(mode == 0 ? "R3" : "R4");
                end
                step(0, 8'h00, 3'b000, 0, 1, 0, 0);
                check_all("R4");
            end
        end

        // R4: accumulation persists until err_clr with a character present
        acc_mode = 1;
        step(1, 8'h41, 3'b001, 0, 0, 0, 0);
        step(1, 8'h42, 3'b100, 0, 0, 0, 0);
        step(0, 8'h00, 3'b000, 1, 0, 0, 0);
        check_all("R4");
        step(0, 8'h00, 3'b000, 0, 1, 0, 0);
        check_all("R4");
        idle();
        check_all("R4");
        step(0, 8'h00, 3'b000, 1, 0, 0, 0);
        check_all("R4");
        acc_mode = 0;

        // R5: pushes, start_det, err_clr do not move the head
        step(1, 8'h55, 3'b010, 0, 0, 0, 0);
        step(1, 8'h66, 3'b000, 0, 0, 0, 1);
        check_all("R5");
        step(0, 8'h00, 3'b000, 0, 1, 0, 1);
        check_all("R5");

        // R6: overrun on push while full, data discarded, sticky
        step(1, 8'h77, 3'b001, 0, 0, 0, 0);
        check_all("R6");
        step(1, 8'hEE, 3'b111, 0, 0, 0, 0);
        check_all("R6");
        for (int k = 0; k < 3; k++) begin
            step(0, 8'h00, 3'b000, 1, 0, 0, 0);
            check_all("R6");
        end
        step(1, 8'h12, 3'b000, 0, 0, 0, 0);
        check_all("R6");
        step(0, 8'h00, 3'b000, 0, 1, 0, 0);
        check_all("R6");

        // R11: simultaneous push and pop while full
        step(1, 8'h13, 3'b010, 0, 0, 0, 0);
        step(1, 8'h14, 3'b100, 0, 0, 0, 0);
        step(1, 8'h15, 3'b011, 1, 0, 0, 0);
        check_all("R11");
        for (int k = 0; k < 3; k++) begin
            step(0, 8'h00, 3'b000, 1, 0, 0, 0);
            check_all("R11");
        end

        // R7 R8: flow control
        flow_en = 1;
        step(1, 8'h21, 3'b000, 0, 0, 0, 1);
        check_all("R8");
        step(1, 8'h22, 3'b000, 0, 0, 0, 0);
        step(1, 8'h23, 3'b000, 0, 0, 0, 0);
        flow_en = 0;
        step(0, 8'h00, 3'b000, 0, 0, 0, 1);
        check_all("R8");
        flow_en = 1;
        step(0, 8'h00, 3'b000, 0, 0, 0, 1);
        check_all("R7");
        chk(rts_n == 1, "R7", "rts_n negated", int'(rts_n), 1);
        step(0, 8'h00, 3'b000, 1, 0, 0, 0);
        check_all("R7");
        idle();
        check_all("R7");
        chk(rts_n == 0, "R7", "rts_n reasserted", int'(rts_n), 0);
        flow_en = 0;

        // R9: receiver reset with entries present, push dropped
        step(1, 8'h31, 3'b101, 0, 0, 0, 0);
        step(1, 8'h99, 3'b111, 0, 0, 1, 0);
        check_all("R9");
        chk(ready == 0 && {stat_brk, stat_fe, stat_pe} == 0, "R9", "empty, clean",
            int'({ready, stat_brk, stat_fe, stat_pe}), 0);

        // R10: pop while empty misaligns pointers, stale head
        step(0, 8'h00, 3'b000, 1, 0, 0, 0);
        check_all("R10");
        step(1, 8'h5A, 3'b001, 0, 0, 0, 0);
        check_all("R10");
        chk(rd_data != 8'h5A, "R10", "head is stale", int'(rd_data), int'(m_data[m_rd]));
        step(0, 8'h00, 3'b000, 0, 0, 1, 0);
        check_all("R9");
        step(1, 8'h6B, 3'b010, 0, 0, 0, 0);
        check_all("R10");
        chk(rd_data == 8'h6B, "R9", "realigned head", int'(rd_data), 8'h6B);
        done = 1;
    end

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: got timeout expected completion");
            end
            wait (done);
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule